// File: doc/BRIEF.md
# Burst Radix Bucket Distributor

This engine splits a stream of keyed words into buckets, using the most significant byte of each word as the key. Words arrive from a memory port in fixed-length read bursts. They are queued in on-chip bucket FIFOs, and each FIFO is twice the burst length deep. Whenever a bucket has gathered a full burst, that burst goes back to memory as a single write transaction. Before each write, the engine requests a destination block from an external list manager. Every memory transfer is therefore a full burst, no matter how the keys are distributed. This holds even when every word carries the same key.

The engine works as one control loop. The decision state `S_SCAN` picks the next action in this order: drain a bucket that has reached the threshold, read another input burst, flush a partly filled bucket, or finish. The states are:

- `S_IDLE`: after reset.
- `S_SCAN`: the decision state.
- `S_RD_REQ`: read request pending.
- `S_RD_DATA`: accepting read beats.
- `S_ALLOC`: block request pending.
- `S_WR_REQ`: write request pending.
- `S_WR_DATA`: emitting write beats.
- `S_DONE`: finished.

The transitions are:

- IDLE→SCAN and DONE→SCAN on `start`.
- SCAN→ALLOC on a full bucket or a pending flush.
- SCAN→RD_REQ when input remains.
- SCAN→DONE when the input is exhausted and all buckets are empty.
- RD_REQ→RD_DATA on `rd_gnt`.
- RD_DATA→SCAN after the last beat.
- ALLOC→WR_REQ on `alloc_gnt`.
- WR_REQ→WR_DATA on `wr_gnt`.
- WR_DATA→SCAN after the last beat.

Top module: `radix_bucket_distributor`

## Requirements
- R1: After reset, `done`, `rd_req`, `alloc_req`, `wr_req` and `wr_valid` are all low, and the engine waits for `start`.
- R2: `rd_req` stays high until `rd_gnt` is seen. The engine then accepts exactly BURST words, one on each cycle where `rd_valid` is high. Gaps in `rd_valid` are allowed.
- R3: A word goes into bucket number `rd_data[DATA_W-1 -: KEY_W]`, which is the top KEY_W bits of the word (8 bits by default, giving 256 buckets). Every written word is emitted under the bucket that matches its own top bits.
- R4: A read burst is requested only while every bucket holds fewer than BURST words. As a result, no bucket ever holds more than 2×BURST words.
- R5: After a read burst completes, any bucket that holds BURST or more words is drained as a full write burst before the next read. All BURST beats of that burst have `wr_keep` high.
- R6: When several buckets are at or above BURST, they are drained in increasing bucket number order.
- R7: Every write burst is handled in three steps:
  - `alloc_req` is raised with the bucket on `alloc_bucket` and held until `alloc_gnt`.
  - `wr_req` is then raised, with `wr_bucket` equal to that same bucket, and held until `wr_gnt`.
  - `wr_valid` is then high on BURST consecutive cycles.
- R8: Once `src_more` is low, partly filled buckets are flushed in increasing bucket order, each as one full-length burst. In that burst, `wr_keep` is high on the first n beats (n = words held) and low after that, and the padded beats carry zero data.
- R9: Within a bucket, words leave in the order they arrived.
- R10: Results are correct for any key distribution, including all words in one bucket.
- R11: `done` rises only when the input is exhausted and all buckets are empty. It stays high, with no new requests, until the next `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a distribution run |
| src_more | input | 1 | High while further input bursts remain |
| rd_req | output | 1 | Read-burst request |
| rd_gnt | input | 1 | Read request accepted |
| rd_valid | input | 1 | Read beat valid |
| rd_data | input | DATA_W | Read beat data |
| alloc_req | output | 1 | Request a block from the list manager |
| alloc_bucket | output | KEY_W | Bucket needing a block |
| alloc_gnt | input | 1 | Block granted |
| wr_req | output | 1 | Write-burst request |
| wr_bucket | output | KEY_W | Bucket being written |
| wr_gnt | input | 1 | Write request accepted |
| wr_valid | output | 1 | Write beat valid |
| wr_data | output | DATA_W | Write beat data (zero on padded beats) |
| wr_keep | output | 1 | Beat holds a real word |
| done | output | 1 | Run finished |

## Verification
The distributor is tried with four input patterns, and each one separates different behaviour:

- **Widely spread keys.** Every word lands in its own bucket, so nothing reaches the threshold. This isolates the end-of-input flush, its ordering and its padding.
- **Same key for every word.** This is the worst skew: every read burst fills one bucket exactly. It shows whether the drain-before-read rule holds occupancy down.
- **Two keys filling together.** Two buckets cross the threshold in the same read burst, which exposes the drain order.
- **Four keys in a rotating but uneven pattern.** This mixes threshold drains with a final flush. Combined with a stall inside every read burst, it checks order preservation and that no word is lost or duplicated.

// File: rtl/bkt_pkg.sv
package bkt_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_SCAN,
        S_RD_REQ,
        S_RD_DATA,
        S_ALLOC,
        S_WR_REQ,
        S_WR_DATA,
        S_DONE
    } dist_state_t;
endpackage

// File: rtl/bucket_store.sv
module bucket_store #(
    parameter int DATA_W = 32,
    parameter int KEY_W  = 8,
    parameter int BURST  = 16,
    parameter int DEPTH  = 32,
    parameter int NB     = 1 << KEY_W,
    parameter int CW     = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    input  logic [KEY_W-1:0]  pop_key,
    output logic [DATA_W-1:0] pop_data,
    input  logic [KEY_W-1:0]  q_key,
    output logic [CW-1:0]     q_cnt,
    output logic [NB-1:0]     over_vec,
    output logic [NB-1:0]     busy_vec
);
    localparam int PW = $clog2(DEPTH);

    logic [DATA_W-1:0] mem  [NB*DEPTH];
    logic [PW-1:0]     head [NB];
    logic [PW-1:0]     tail [NB];
    logic [CW-1:0]     cnt  [NB];
    logic [KEY_W-1:0]  push_key;

    assign push_key = push_data[DATA_W-1 -: KEY_W];
    assign pop_data = mem[{pop_key, head[pop_key]}];
    assign q_cnt    = cnt[q_key];

    always_ff @(posedge clk) begin
        if (push) begin
            mem[{push_key, tail[push_key]}] <= push_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int b = 0; b < NB; b++) begin
                head[b] <= '0;
                tail[b] <= '0;
                cnt[b]  <= '0;
            end
        end else begin
            if (push) begin
                tail[push_key] <= tail[push_key] + 1'b1;
                cnt[push_key]  <= cnt[push_key] + 1'b1;
            end
            if (pop) begin
                head[pop_key] <= head[pop_key] + 1'b1;
                cnt[pop_key]  <= cnt[pop_key] - 1'b1;
            end
        end
    end

    always_comb begin
        for (int b = 0; b < NB; b++) begin
            over_vec[b] = (cnt[b] >= CW'(BURST));
            busy_vec[b] = (cnt[b] != '0);
        end
    end

    // R4: a bucket never receives a word when it is already full
    a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (cnt[push_key] < CW'(DEPTH)));
    // R9: a pop only ever takes from a bucket that holds a word
    a_r9_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (cnt[pop_key] != '0));
    a_r9_one_port: assert property (@(posedge clk) disable iff (!rst_n)
        !(push && pop));
endmodule

// File: rtl/lowest_pick.sv
module lowest_pick #(
    parameter int N  = 256,
    parameter int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  vec,
    output logic [IW-1:0] idx,
    output logic          hit
);
    always_comb begin
        idx = '0;
        hit = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                idx = IW'(i);
                hit = 1'b1;
            end
        end
    end

    // R6: the chosen index is set and no lower index is set
    a_r6_lowest_first: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (vec[idx] && ((vec & ((N'(1) << idx) - N'(1))) == '0)));
    a_r6_no_false_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (vec == '0) |-> !hit);
endmodule

// File: rtl/radix_bucket_distributor.sv
module radix_bucket_distributor #(
    parameter int DATA_W = 32,
    parameter int KEY_W  = 8,
    parameter int BURST  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              src_more,
    output logic              rd_req,
    input  logic              rd_gnt,
    input  logic              rd_valid,
    input  logic [DATA_W-1:0] rd_data,
    output logic              alloc_req,
    output logic [KEY_W-1:0]  alloc_bucket,
    input  logic              alloc_gnt,
    output logic              wr_req,
    output logic [KEY_W-1:0]  wr_bucket,
    input  logic              wr_gnt,
    output logic              wr_valid,
    output logic [DATA_W-1:0] wr_data,
    output logic              wr_keep,
    output logic              done
);
    import bkt_pkg::*;

    localparam int DEPTH = 2 * BURST;
    localparam int NB    = 1 << KEY_W;
    localparam int CW    = $clog2(DEPTH + 1);

    dist_state_t       state_q, state_d;
    logic [CW-1:0]     beat_q;
    logic [CW-1:0]     n_q;
    logic [KEY_W-1:0]  sel_q;
    logic              last_beat;

    logic [NB-1:0]     over_vec, busy_vec;
    logic [KEY_W-1:0]  over_idx, busy_idx, q_key;
    logic              over_hit, busy_hit;
    logic [CW-1:0]     q_cnt;
    logic              push, pop;
    logic [DATA_W-1:0] pop_data;

    bucket_store #(
        .DATA_W(DATA_W), .KEY_W(KEY_W), .BURST(BURST), .DEPTH(DEPTH),
        .NB(NB), .CW(CW)
    ) u_store (
        .clk(clk), .rst_n(rst_n),
        .push(push), .push_data(rd_data),
        .pop(pop), .pop_key(sel_q), .pop_data(pop_data),
        .q_key(q_key), .q_cnt(q_cnt),
        .over_vec(over_vec), .busy_vec(busy_vec)
    );

    lowest_pick #(.N(NB), .IW(KEY_W)) u_pick_full (
        .clk(clk), .rst_n(rst_n), .vec(over_vec), .idx(over_idx), .hit(over_hit)
    );

    lowest_pick #(.N(NB), .IW(KEY_W)) u_pick_part (
        .clk(clk), .rst_n(rst_n), .vec(busy_vec), .idx(busy_idx), .hit(busy_hit)
    );

    assign q_key     = over_hit ? over_idx : busy_idx;
    assign last_beat = (beat_q == CW'(BURST - 1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:    if (start) state_d = S_SCAN;
            S_SCAN: begin
                if (over_hit)      state_d = S_ALLOC;
                else if (src_more) state_d = S_RD_REQ;
                else if (busy_hit) state_d = S_ALLOC;
                else               state_d = S_DONE;
            end
            S_RD_REQ:  if (rd_gnt) state_d = S_RD_DATA;
            S_RD_DATA: if (rd_valid && last_beat) state_d = S_SCAN;
            S_ALLOC:   if (alloc_gnt) state_d = S_WR_REQ;
            S_WR_REQ:  if (wr_gnt) state_d = S_WR_DATA;
            S_WR_DATA: if (last_beat) state_d = S_SCAN;
            S_DONE:    if (start) state_d = S_SCAN;
            default:   state_d = S_IDLE;
        endcase
    end

    // datapath registers: beat counter, selected bucket, kept-word count
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            beat_q <= '0;
            n_q    <= '0;
            sel_q  <= '0;
        end else begin
            if (state_q == S_SCAN) begin
                beat_q <= '0;
                sel_q  <= q_key;
                n_q    <= over_hit ? CW'(BURST) : q_cnt;
            end else if ((state_q == S_RD_DATA && rd_valid) || state_q == S_WR_DATA) begin
                beat_q <= last_beat ? '0 : beat_q + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        rd_req    = 1'b0;
        alloc_req = 1'b0;
        wr_req    = 1'b0;
        wr_valid  = 1'b0;
        wr_keep   = 1'b0;
        done      = 1'b0;
        push      = 1'b0;
        pop       = 1'b0;
        unique case (state_q)
            S_RD_REQ:  rd_req = 1'b1;
            S_RD_DATA: push = rd_valid;
            S_ALLOC:   alloc_req = 1'b1;
            S_WR_REQ:  wr_req = 1'b1;
            S_WR_DATA: begin
                wr_valid = 1'b1;
                wr_keep  = (beat_q < n_q);
                pop      = (beat_q < n_q);
            end
            S_DONE:    done = 1'b1;
            default:   ;
        endcase
    end

    assign alloc_bucket = sel_q;
    assign wr_bucket    = sel_q;
    assign wr_data      = wr_keep ? pop_data : '0;

    // R4: no read is requested while a bucket is at or over the threshold
    a_r4_read_room: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> (over_vec == '0));
    // R2: the read request is held until granted
    a_r2_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_gnt) |=> rd_req);
    // R7: block request held with a stable bucket until granted
    a_r7_alloc_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_req && !alloc_gnt) |=> (alloc_req && $stable(alloc_bucket)));
    // R7: a write burst never stops after its first beat
    a_r7_wr_run: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_valid) |=> wr_valid);
    // R11: finished only with every bucket empty
    a_r11_done_empty: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (busy_vec == '0));
    // R8: a padded beat is never followed by a kept beat in the same burst
    a_r8_pad_tail: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_keep) |=> !wr_keep);
endmodule

// File: tb/tb_radix_bucket_distributor.sv
module tb_radix_bucket_distributor;
    localparam int DW = 32;
    localparam int KW = 8;
    localparam int BL = 16;
    localparam int NB = 256;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic src_more;
    logic rd_req, rd_gnt = 1'b0, rd_valid = 1'b0;
    logic [DW-1:0] rd_data = '0;
    logic alloc_req, alloc_gnt = 1'b0;
    logic [KW-1:0] alloc_bucket, wr_bucket;
    logic wr_req, wr_gnt = 1'b0, wr_valid, wr_keep, done;
    logic [DW-1:0] wr_data;

    always #10 clk = ~clk;

    radix_bucket_distributor #(.DATA_W(DW), .KEY_W(KW), .BURST(BL)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .src_more(src_more),
        .rd_req(rd_req), .rd_gnt(rd_gnt), .rd_valid(rd_valid), .rd_data(rd_data),
        .alloc_req(alloc_req), .alloc_bucket(alloc_bucket), .alloc_gnt(alloc_gnt),
        .wr_req(wr_req), .wr_bucket(wr_bucket), .wr_gnt(wr_gnt),
        .wr_valid(wr_valid), .wr_data(wr_data), .wr_keep(wr_keep), .done(done)
    );

    int total = 0;
    int bad = 0;

    logic [DW-1:0] src_q [$];
    logic [DW-1:0] out_q [$];
    int bb_bkt [$];
    int bb_keep [$];
    int src_pos = 0;
    int occ [NB];
    int rd_left = 0;
    int stalled = 0;
    int a_bkt = 0;
    int beat = 0;
    int nkeep = 0;
    int saw_pad = 0;
    int err_occ = 0, err_key = 0, err_pad = 0, err_alloc = 0, err_len = 0;

    assign src_more = (src_pos < src_q.size());

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // memory and list-manager responder
    always @(negedge clk) begin
        if (rst_n) begin
            // write capture
            if (wr_valid) begin
                beat++;
                if (wr_keep) begin
                    if (saw_pad != 0) err_pad++;
                    if (int'(wr_data[DW-1 -: KW]) != int'(wr_bucket)) err_key++;
                    out_q.push_back(wr_data);
                    occ[wr_bucket]--;
                    nkeep++;
                end else begin
                    saw_pad = 1;
                    if (wr_data != '0) err_pad++;
                end
                if (beat == BL) begin
                    bb_bkt.push_back(int'(wr_bucket));
                    bb_keep.push_back(nkeep);
                    beat = 0;
                end
            end else if (beat != 0) begin
                err_len++;
                beat = 0;
            end
            // read side
            rd_valid = 1'b0;
            if (rd_gnt) begin
                rd_gnt = 1'b0;
                rd_left = BL;
                stalled = 0;
            end else if (rd_left > 0) begin
                if (rd_left == 7 && stalled == 0) begin
                    stalled = 1;
                end else begin
                    rd_valid = 1'b1;
                    rd_data = src_q[src_pos];
                    occ[src_q[src_pos][DW-1 -: KW]]++;
                    src_pos++;
                    rd_left--;
                end
            end else if (rd_req) begin
                for (int b = 0; b < NB; b++) if (occ[b] >= BL) err_occ++;
                rd_gnt = 1'b1;
            end
            // allocation
            if (alloc_gnt) alloc_gnt = 1'b0;
            else if (alloc_req) begin
                alloc_gnt = 1'b1;
                a_bkt = int'(alloc_bucket);
            end
            // write grant
            if (wr_gnt) wr_gnt = 1'b0;
            else if (wr_req) begin
                wr_gnt = 1'b1;
                if (int'(wr_bucket) != a_bkt) err_alloc++;
                nkeep = 0;
                saw_pad = 0;
            end
        end
    end

    function automatic logic [KW-1:0] key_of(input int mode, input int i);
        case (mode)
            0: return KW'((i * 37 + 11) & 255);
            1: return 8'h7A;
            2: return ((i % 16) < 8) ? 8'd5 : 8'd3;
            default: return KW'((((i * 13) ^ (i >> 2)) & 3) * 64 + 1);
        endcase
    endfunction

    task automatic load(input int mode, input int bursts, input int tag);
        src_q.delete();
        out_q.delete();
        bb_bkt.delete();
        bb_keep.delete();
        src_pos = 0;
        for (int b = 0; b < NB; b++) occ[b] = 0;
        err_occ = 0; err_key = 0; err_pad = 0; err_alloc = 0; err_len = 0;
        for (int i = 0; i < bursts * BL; i++)
            src_q.push_back({key_of(mode, i), 8'(tag), 16'(i)});
    endtask

    task automatic run_to_done(input string req);
        int cyc;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 0;
        while (!done && cyc < 20000) begin
            @(negedge clk);
            cyc++;
        end
        chk(done == 1'b1, req, "run reached done (watchdog)", cyc, 0);
    endtask

    task automatic check_common(input string tname);
        int mism = 0;
        for (int b = 0; b < NB; b++) begin
            int j = 0;
            for (int i = 0; i < src_q.size(); i++) begin
                if (int'(src_q[i][DW-1 -: KW]) == b) begin
                    while (j < out_q.size() && int'(out_q[j][DW-1 -: KW]) != b) j++;
                    if (j >= out_q.size() || out_q[j] != src_q[i]) mism++;
                    j++;
                end
            end
        end
        // R9 and R3: per-bucket order and membership
        chk(mism == 0 && out_q.size() == src_q.size(), "R9",
            {tname, " order kept within buckets"}, mism, 0);
        chk(err_key == 0, "R3", {tname, " word key matches bucket"}, err_key, 0);
        // R4: occupancy below threshold at every read request
        chk(err_occ == 0, "R4", {tname, " bucket occupancy at read request"}, err_occ, 0);
        // R8 / R7: padding tail and burst structure
        chk(err_pad == 0, "R8", {tname, " pad beats trail and are zero"}, err_pad, 0);
        chk(err_alloc == 0 && err_len == 0, "R7",
            {tname, " alloc bucket and burst length"}, err_alloc + err_len, 0);
    endtask

    task automatic t_reset;
        chk(!done && !rd_req && !alloc_req && !wr_req && !wr_valid, "R1",
            "outputs idle after reset",
            int'({done, rd_req, alloc_req, wr_req, wr_valid}), 0);
        repeat (3) @(negedge clk);
        chk(!rd_req && !done, "R1", "waits for start", int'({rd_req, done}), 0);
    endtask

    task automatic t_spread;
        int ok_order = 1;
        int ok_keep = 1;
        load(0, 4, 1);
        run_to_done("R8");
        check_common("spread");
        chk(bb_bkt.size() == 64, "R8", "flush burst count", bb_bkt.size(), 64);
        for (int k = 0; k < bb_bkt.size(); k++) begin
            if (bb_keep[k] != 1) ok_keep = 0;
            if (k > 0 && bb_bkt[k] <= bb_bkt[k-1]) ok_order = 0;
        end
        chk(ok_keep == 1, "R8", "one kept word per flush", ok_keep, 1);
        chk(ok_order == 1, "R8", "flush in rising bucket order", ok_order, 1);
    endtask

    task automatic t_one_bucket;
        int full = 0;
        load(1, 6, 2);
        run_to_done("R10");
        check_common("skew");
        for (int k = 0; k < bb_keep.size(); k++) if (bb_keep[k] == BL) full++;
        chk(bb_bkt.size() == 6, "R10", "bursts for single bucket", bb_bkt.size(), 6);
        chk(full == 6, "R5", "all bursts fully kept", full, 6);
    endtask

    task automatic t_tie;
        load(2, 2, 3);
        run_to_done("R6");
        check_common("tie");
        chk(bb_bkt.size() == 2, "R6", "two drains", bb_bkt.size(), 2);
        if (bb_bkt.size() == 2) begin
            chk(bb_bkt[0] == 3, "R6", "first drained bucket", bb_bkt[0], 3);
            chk(bb_bkt[1] == 5, "R6", "second drained bucket", bb_bkt[1], 5);
            chk(bb_keep[0] == BL && bb_keep[1] == BL, "R5", "tie bursts full",
                bb_keep[0] + bb_keep[1], 2 * BL);
        end
    endtask

    task automatic t_mixed;
        int kept = 0;
        int reqs = 0;
        load(3, 10, 4);
        run_to_done("R2");
        check_common("mixed");
        for (int k = 0; k < bb_keep.size(); k++) kept += bb_keep[k];
        chk(kept == 10 * BL, "R2", "all stalled read beats delivered", kept, 10 * BL);
        chk(src_pos == 10 * BL, "R2", "input fully consumed", src_pos, 10 * BL);
        for (int c = 0; c < 5; c++) begin
            @(negedge clk);
            if (!done || rd_req || alloc_req || wr_req) reqs++;
        end
        chk(reqs == 0, "R11", "done holds with no requests", reqs, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_spread();
        t_one_bucket();
        t_tie();
        t_mixed();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule